// File: doc/BRIEF.md
# MSI Doorbell Interrupt Bank

This block gathers message-signalled interrupts for a single bank of 32 vectors and turns them into one level interrupt for the CPU. Software sets it up through a 32-bit register port. It programs a 64-bit doorbell address, an enable word, a mask word and a pending-status word. An endpoint raises vector `v` by writing the value `v` to the doorbell address as a full 32-bit write. The block records that write as pending status bit `v`, provided the vector is enabled.

The interrupt output is a sticky level. It rises when a doorbell write leaves any unmasked status bit pending. Software acknowledges vectors by writing ones to the status word, and each written one toggles its bit. The output falls only when such a status write leaves the whole status word at zero. Changing the mask never moves the output on its own. The doorbell window is only open while the enable word is nonzero.

Register reads are registered: the data appears on `regRdata` one clock after the read request and holds until the next read.

Top module: `msi_doorbell_bank`

## Requirements
- R1: After reset, the doorbell address, enable, mask and status registers all read as zero, `irqOut` is low and `regRdata` is zero.
- R2: A write to offset 0x820 replaces only bits 31:0 of the doorbell address, and a write to 0x824 replaces only bits 63:32. Reading either offset returns that half.
- R3: The enable word (offset 0x828) and the mask word (offset 0x82C) read back exactly as they were last written.
- R4: A doorbell write has `dbValid` high, `dbByteEn` equal to 4'b1111 and `dbAddr` equal to the 64-bit doorbell address. If its data `v` is below 32 and enable bit `v` is set, status bit `v` is set after that clock edge, and no other status bit changes.
- R5: A doorbell write leaves the status word unchanged in each of these cases: enable bit `v` is clear, `v` is 32 or more, any byte enable is low, or the address differs from the doorbell address.
- R6: While the enable word is zero, no doorbell write changes the status word. Once the enable word is nonzero again, matching doorbell writes are captured again.
- R7: `irqOut` rises on the clock edge of an accepted doorbell write (R4 address, byte-enable and range conditions) after which some status bit is set whose mask bit is clear. A doorbell write that leaves only masked bits pending does not raise it.
- R8: A write to the status word (offset 0x830) XORs the written data into the status word.
- R9: `irqOut` falls only on the edge of a status write that leaves the status word all zero. A status write that leaves any bit set, masked or not, keeps `irqOut` unchanged.
- R10: A write to the mask word never changes `irqOut`.
- R11: A read from any other offset returns zero, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data, loaded one cycle after a read request |
| dbValid | input | 1 | Inbound memory write present this cycle |
| dbAddr | input | 64 | Inbound write address |
| dbData | input | 32 | Inbound write data (vector number) |
| dbByteEn | input | 4 | Inbound write byte enables |
| irqOut | output | 1 | Level interrupt to the CPU |

## Verification
Register writes, doorbell captures and `irqOut` changes all take effect on the clock edge at which the request is presented. Read data is one edge later, because it passes through the registered read port. The bench drives each request on a falling edge and removes it on the next falling edge. It then samples `irqOut` at that second falling edge, one register after the stimulus. It reads status back with a read request and samples `regRdata` a further falling edge later. The expected values come from a bench model that is updated once for each request, so every comparison lines up with the cycle in which the result is due.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_ENABLE  = 3'd3,
    SEL_MASK    = 3'd4,
    SEL_STATUS  = 3'd5
  } regSel_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    wrAddrLo;
    logic    wrAddrHi;
    logic    wrEnable;
    logic    wrMask;
    logic    wrStatus;
    logic    rdLoad;
    regSel_e rdSel;
    logic    dbHit;
  } strobes_t;

endpackage

// File: rtl/msi_bank_ctrl.sv
module msi_bank_ctrl
  import msi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_ADDR_LO = 'h820,
  parameter logic [ADDR_W-1:0] OFF_ADDR_HI = 'h824,
  parameter logic [ADDR_W-1:0] OFF_ENABLE  = 'h828,
  parameter logic [ADDR_W-1:0] OFF_MASK    = 'h82C,
  parameter logic [ADDR_W-1:0] OFF_STATUS  = 'h830,
  localparam int unsigned VEC_W  = $clog2(DATA_W),
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned DADR_W = 2 * DATA_W
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              dbValid,
  input  logic [DADR_W-1:0] dbAddr,
  input  logic [DATA_W-1:0] dbData,
  input  logic [BE_W-1:0]   dbByteEn,
  input  logic [DADR_W-1:0] curBase,
  input  logic              windowOpen,
  output strobes_t          stb,
  output logic [VEC_W-1:0]  dbVec
);

  logic    isWr;
  logic    isRd;
  regSel_e sel;
  logic    vecInRange;
  logic    fullWord;
  logic    addrMatch;

  always_comb begin
    if (regAddr == OFF_ADDR_LO)      sel = SEL_ADDR_LO;
    else if (regAddr == OFF_ADDR_HI) sel = SEL_ADDR_HI;
    else if (regAddr == OFF_ENABLE)  sel = SEL_ENABLE;
    else if (regAddr == OFF_MASK)    sel = SEL_MASK;
    else if (regAddr == OFF_STATUS)  sel = SEL_STATUS;
    else                             sel = SEL_NONE;
  end

  assign isWr = regValid && regWrite;
  assign isRd = regValid && !regWrite;

  assign vecInRange = (dbData < DATA_W);
  assign fullWord   = &dbByteEn;
  assign addrMatch  = (dbAddr == curBase);
  assign dbVec      = dbData[VEC_W-1:0];

  always_comb begin
    stb          = '0;
    stb.wrAddrLo = isWr && (sel == SEL_ADDR_LO);
    stb.wrAddrHi = isWr && (sel == SEL_ADDR_HI);
    stb.wrEnable = isWr && (sel == SEL_ENABLE);
    stb.wrMask   = isWr && (sel == SEL_MASK);
    stb.wrStatus = isWr && (sel == SEL_STATUS);
    stb.rdLoad   = isRd;
    stb.rdSel    = sel;
    stb.dbHit    = dbValid && windowOpen && fullWord && addrMatch && vecInRange;
  end

endmodule

// File: rtl/msi_bank_datapath.sv
module msi_bank_datapath
  import msi_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VEC_W  = $clog2(DATA_W),
  localparam int unsigned DADR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [VEC_W-1:0]  dbVec,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [DADR_W-1:0] curBase,
  output logic              windowOpen,
  output logic [DATA_W-1:0] enableWord,
  output logic [DATA_W-1:0] maskWord,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] statusNext
);

  logic [DATA_W-1:0] baseLo;
  logic [DATA_W-1:0] baseHi;
  logic [DATA_W-1:0] setBits;
  logic [DATA_W-1:0] afterToggle;
  logic [DATA_W-1:0] rdMux;

  // Per-vector capture: a bit is set only for the addressed, enabled vector
  for (genvar i = 0; i < DATA_W; i++) begin : g_capture
    assign setBits[i] = stb.dbHit && (dbVec == VEC_W'(i)) && enableWord[i];
  end

  assign afterToggle = stb.wrStatus ? (statusWord ^ regWdata) : statusWord;
  assign statusNext  = afterToggle | setBits;
  assign curBase     = {baseHi, baseLo};
  assign windowOpen  = |enableWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseLo     <= '0;
      baseHi     <= '0;
      enableWord <= '0;
      maskWord   <= '0;
      statusWord <= '0;
    end else begin
      if (stb.wrAddrLo) baseLo     <= regWdata;
      if (stb.wrAddrHi) baseHi     <= regWdata;
      if (stb.wrEnable) enableWord <= regWdata;
      if (stb.wrMask)   maskWord   <= regWdata;
      statusWord <= statusNext;
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_ADDR_LO: rdMux = baseLo;
      SEL_ADDR_HI: rdMux = baseHi;
      SEL_ENABLE:  rdMux = enableWord;
      SEL_MASK:    rdMux = maskWord;
      SEL_STATUS:  rdMux = statusWord;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             regRdata <= '0;
    else if (stb.rdLoad) regRdata <= rdMux;
  end

endmodule

// File: rtl/msi_bank_irq.sv
module msi_bank_irq #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbHit,
  input  logic              wrStatus,
  input  logic [DATA_W-1:0] statusNext,
  input  logic [DATA_W-1:0] maskWord,
  output logic              irqOut
);

  logic raise;
  logic drop;

  // Raised only by doorbell traffic, dropped only by a clearing status write
  assign raise = dbHit && |(statusNext & ~maskWord);
  assign drop  = wrStatus && (statusNext == '0);

  always_ff @(posedge clk) begin
    if (rst)        irqOut <= 1'b0;
    else if (raise) irqOut <= 1'b1;
    else if (drop)  irqOut <= 1'b0;
  end

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
  import msi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_ADDR_LO = 'h820,
  parameter logic [ADDR_W-1:0] OFF_ADDR_HI = 'h824,
  parameter logic [ADDR_W-1:0] OFF_ENABLE  = 'h828,
  parameter logic [ADDR_W-1:0] OFF_MASK    = 'h82C,
  parameter logic [ADDR_W-1:0] OFF_STATUS  = 'h830,
  localparam int unsigned VEC_W  = $clog2(DATA_W),
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned DADR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dbValid,
  input  logic [DADR_W-1:0] dbAddr,
  input  logic [DATA_W-1:0] dbData,
  input  logic [BE_W-1:0]   dbByteEn,
  output logic              irqOut
);

  strobes_t          stb;
  logic [VEC_W-1:0]  dbVec;
  logic [DADR_W-1:0] curBase;
  logic              windowOpen;
  logic [DATA_W-1:0] enableWord;
  logic [DATA_W-1:0] maskWord;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] statusNext;

  msi_bank_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFF_ADDR_LO(OFF_ADDR_LO), .OFF_ADDR_HI(OFF_ADDR_HI),
    .OFF_ENABLE(OFF_ENABLE), .OFF_MASK(OFF_MASK), .OFF_STATUS(OFF_STATUS)
  ) u_ctrl (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .dbValid(dbValid), .dbAddr(dbAddr), .dbData(dbData), .dbByteEn(dbByteEn),
    .curBase(curBase), .windowOpen(windowOpen),
    .stb(stb), .dbVec(dbVec)
  );

  msi_bank_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .dbVec(dbVec), .regWdata(regWdata),
    .regRdata(regRdata), .curBase(curBase), .windowOpen(windowOpen),
    .enableWord(enableWord), .maskWord(maskWord),
    .statusWord(statusWord), .statusNext(statusNext)
  );

  msi_bank_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .dbHit(stb.dbHit), .wrStatus(stb.wrStatus),
    .statusNext(statusNext), .maskWord(maskWord), .irqOut(irqOut)
  );

endmodule

// File: rtl/msi_doorbell_bank_chk.sv
module msi_doorbell_bank_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 'h82C,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 'h830
) (
  input logic              clk,
  input logic              rst,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              dbValid,
  input logic              irqOut,
  input logic [DATA_W-1:0] enableWord,
  input logic [DATA_W-1:0] statusWord
);

  logic stsWr;
  logic maskWr;
  assign stsWr  = regValid && regWrite && (regAddr == OFF_STATUS);
  assign maskWr = regValid && regWrite && (regAddr == OFF_MASK);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(dbValid));

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(irqOut) |-> ($past(stsWr) && statusWord == '0));

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (maskWr && !dbValid) |=> $stable(irqOut));

  assert_window_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (enableWord == '0 && !stsWr) |=> $stable(statusWord));

  assert_status_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (stsWr && !dbValid) |=> (statusWord == $past(statusWord ^ regWdata)));

endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_MASK(OFF_MASK), .OFF_STATUS(OFF_STATUS)
) u_chk (
  .clk(clk), .rst(rst), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regWdata(regWdata), .dbValid(dbValid), .irqOut(irqOut),
  .enableWord(enableWord), .statusWord(statusWord)
);

// File: tb/sim_msi_doorbell_bank.sv
module sim_msi_doorbell_bank;

  localparam logic [11:0] A_LO  = 12'h820;
  localparam logic [11:0] A_HI  = 12'h824;
  localparam logic [11:0] A_EN  = 12'h828;
  localparam logic [11:0] A_MSK = 12'h82C;
  localparam logic [11:0] A_STS = 12'h830;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        dbValid = 1'b0;
  logic [63:0] dbAddr = '0;
  logic [31:0] dbData = '0;
  logic [3:0]  dbByteEn = '0;
  logic        irqOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  // Bench model state
  logic [31:0] mLo, mHi, mEn, mMsk, mSts;
  logic        mIrq;

  always #2 clk = ~clk;

  msi_doorbell_bank u0 (
    .clk(clk), .rst(rst), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .dbValid(dbValid), .dbAddr(dbAddr), .dbData(dbData),
    .dbByteEn(dbByteEn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] regModel(input logic [11:0] a);
    case (a)
      A_LO:    return mLo;
      A_HI:    return mHi;
      A_EN:    return mEn;
      A_MSK:   return mMsk;
      A_STS:   return mSts;
      default: return 32'h0;
    endcase
  endfunction

  task automatic regWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    case (a)
      A_LO:  mLo  = d;
      A_HI:  mHi  = d;
      A_EN:  mEn  = d;
      A_MSK: mMsk = d;
      A_STS: begin
        mSts = mSts ^ d;
        if (mSts == 32'h0) mIrq = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic regRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  task automatic doorbell(input logic [63:0] a, input logic [31:0] v, input logic [3:0] be);
    logic hit;
    @(negedge clk);
    dbValid = 1'b1; dbAddr = a; dbData = v; dbByteEn = be;
    @(negedge clk);
    dbValid = 1'b0;
    hit = (mEn != 0) && (be == 4'hF) && (a == {mHi, mLo}) && (v < 32);
    if (hit) begin
      mSts = mSts | ((32'h1 << v[4:0]) & mEn);
      if ((mSts & ~mMsk) != 0) mIrq = 1'b1;
    end
  endtask

  task automatic checkReg(input string tag, input logic [11:0] a);
    logic [31:0] d;
    regRd(a, d);
    check(tag, {32'h0, d}, {32'h0, regModel(a)});
  endtask

  task automatic checkIrq(input string tag);
    check(tag, {63'h0, irqOut}, {63'h0, mIrq});
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] base;
    void'($urandom(32'd20240607));
    mLo = 0; mHi = 0; mEn = 0; mMsk = 0; mSts = 0; mIrq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {63'h0, irqOut}, 64'h0);
    check("R1 rdata", {32'h0, regRdata}, 64'h0);
    checkReg("R1 addrLo", A_LO);
    checkReg("R1 addrHi", A_HI);
    checkReg("R1 enable", A_EN);
    checkReg("R1 mask", A_MSK);
    checkReg("R1 status", A_STS);

    // R2: address halves
    regWr(A_LO, 32'hFEE0_0040);
    regWr(A_HI, 32'h0000_0001);
    checkReg("R2 lo", A_LO);
    checkReg("R2 hi", A_HI);
    regWr(A_LO, 32'hFEE0_1000);
    checkReg("R2 hi kept", A_HI);
    checkReg("R2 lo replaced", A_LO);
    regWr(A_HI, 32'h0000_0002);
    checkReg("R2 lo kept", A_LO);
    base = {mHi, mLo};

    // R3: enable and mask readback
    regWr(A_MSK, 32'hA5A5_5A5A);
    checkReg("R3 mask", A_MSK);
    regWr(A_MSK, 32'h0);
    checkReg("R3 mask zero", A_MSK);

    // R6: window closed while enable is zero
    doorbell(base, 32'd3, 4'hF);
    checkReg("R6 closed status", A_STS);
    check("R6 closed status zero", {32'h0, mSts}, 64'h0);
    checkIrq("R6 closed irq");

    // R4 / R7: accepted doorbell
    regWr(A_EN, 32'h0000_00FF);
    checkReg("R3 enable", A_EN);
    doorbell(base, 32'd3, 4'hF);
    check("R7 irq rises", {63'h0, irqOut}, 64'h1);
    checkReg("R4 status bit3", A_STS);
    check("R4 status value", {32'h0, mSts}, 64'h8);

    // R5: ignored doorbells
    doorbell(base, 32'd10, 4'hF);
    checkReg("R5 disabled vector", A_STS);
    doorbell(base, 32'd40, 4'hF);
    checkReg("R5 out of range", A_STS);
    doorbell(base, 32'd4, 4'h3);
    checkReg("R5 partial bytes", A_STS);
    doorbell(base ^ 64'h4, 32'd5, 4'hF);
    checkReg("R5 wrong address", A_STS);
    check("R5 status still 8", {32'h0, mSts}, 64'h8);

    // R10 then R9/R8
    regWr(A_MSK, 32'hFFFF_FFFF);
    check("R10 mask all keeps irq", {63'h0, irqOut}, 64'h1);
    regWr(A_STS, 32'h8);
    check("R9 clear drops irq", {63'h0, irqOut}, 64'h0);
    checkReg("R8 status cleared", A_STS);

    // R7 masked: no rise
    doorbell(base, 32'd2, 4'hF);
    check("R7 masked no rise", {63'h0, irqOut}, 64'h0);
    regWr(A_MSK, 32'h0);
    check("R10 unmask no rise", {63'h0, irqOut}, 64'h0);
    regWr(A_STS, 32'h5);
    checkReg("R8 toggle sets", A_STS);
    check("R8 toggle value", {32'h0, mSts}, 64'h1);
    regWr(A_STS, 32'h1);
    checkReg("R8 toggle back", A_STS);

    // R9: partial clear keeps irq high
    doorbell(base, 32'd1, 4'hF);
    doorbell(base, 32'd2, 4'hF);
    check("R7 irq up", {63'h0, irqOut}, 64'h1);
    regWr(A_STS, 32'h2);
    check("R9 partial keeps irq", {63'h0, irqOut}, 64'h1);
    regWr(A_STS, 32'h4);
    check("R9 full clear drops", {63'h0, irqOut}, 64'h0);

    // R6: reopen window
    regWr(A_EN, 32'h0);
    doorbell(base, 32'd0, 4'hF);
    checkReg("R6 closed again", A_STS);
    regWr(A_EN, 32'h1);
    doorbell(base, 32'd0, 4'hF);
    checkReg("R6 reopened", A_STS);
    check("R6 reopened value", {32'h0, mSts}, 64'h1);
    regWr(A_STS, 32'h1);

    // R11: unmapped offsets
    regWr(12'h834, 32'hFFFF_FFFF);
    regWr(12'h000, 32'h1234_5678);
    regRd(12'h834, rd);
    check("R11 unmapped read", {32'h0, rd}, 64'h0);
    checkReg("R11 lo intact", A_LO);
    checkReg("R11 enable intact", A_EN);
    checkReg("R11 status intact", A_STS);

    // Random mix
    regWr(A_EN, 32'hFFFF_FFFF);
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) begin
        logic [3:0] be;
        logic [63:0] a;
        be = ($urandom_range(0, 7) == 0) ? 4'h7 : 4'hF;
        a  = ($urandom_range(0, 7) == 0) ? (base + 64'h4) : base;
        doorbell(a, $urandom_range(0, 39), be);
        checkIrq("R7 random doorbell irq");
      end else if (op < 7) begin
        logic [31:0] d;
        d = ($urandom_range(0, 2) == 0) ? mSts : (mSts & $urandom);
        regWr(A_STS, d);
        checkIrq("R9 random status irq");
      end else if (op == 7) begin
        regWr(A_MSK, $urandom & $urandom);
        checkIrq("R10 random mask irq");
      end else begin
        logic [31:0] e;
        e = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
        regWr(A_EN, e);
        checkIrq("R6 random enable irq");
      end
      checkReg("R4 random status", A_STS);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule